// File: doc/BRIEF.md
# Integer-N Synthesizer Divider Control

This block holds the digital part of an integer-N frequency synthesizer loop. It runs on the reference clock. A programmable reference divider produces one compare tick every R reference cycles. A dual-modulus feedback divider counts pulses from an external 8/9 prescaler. Its swallow counter (A) keeps the prescaler at divide-by-9 for the first A pulses of each cycle, and its main counter (B) ends the cycle after B pulses. The total VCO division is therefore 8·B + A, with B no smaller than A.

A phase-frequency detector compares the two ticks and drives pump source and sink requests. A 2-bit manual mode can force the pump up, force it down or switch it off. A polarity bit swaps the two pump outputs.

A lock detector counts consecutive reference periods in which every pump pulse stays short. A fast-acquire timer raises the pump current code to full scale for a window of U reference periods. A configuration load pulse restarts this window, and so does a loss of lock. The prescaler pulse input is a single-cycle strobe that is already synchronous to the reference clock.

Top module: `syn_divctl`

## Requirements
- R1: `ref_tick` is high for one cycle every R cycles (R = `cfg_ref_div`, legal 3..16383). The first tick falls in cycle R-1, where cycle 0 is the first cycle after a `cfg_load` pulse has been registered.
- R2: `fb_tick` is high only in a cycle where `pre_edge` is high. It marks the B-th prescaler pulse of each feedback period (B = `cfg_b`, at least 1), counting from `cfg_load` or from the previous `fb_tick`.
- R3: `mod_sel` (1 = divide-by-9, 0 = divide-by-8) is high during exactly the first A prescaler pulses of each feedback period (A = `cfg_a`, A ≤ B).
- R4: In the cycle after a `ref_tick`, the phase detector raises its up request, and it holds it until the cycle after the next `fb_tick`. The down request works the same way with the roles of the two ticks swapped. A tick pair in the same cycle produces no pulse. `pump_src` and `pump_sink` are never high together.
- R5: The pump mode `cfg_pump_mode` works as follows: 0 passes the detector requests, 1 forces an up request, 2 forces a down request, 3 turns both outputs off.
- R6: With `cfg_invert` = 0, an up request drives `pump_src` and a down request drives `pump_sink`. With `cfg_invert` = 1, the two are swapped.
- R7: `pump_code` equals `cfg_cur_code` while `boost` is low, and equals 7 while `boost` is high.
- R8: With `cfg_fa_en` = 1, `boost` is high for exactly U·R cycles starting at cycle 0 after a `cfg_load` (U = `cfg_fa_units`). With `cfg_fa_en` = 0, `boost` stays low.
- R9: `locked` is high once `cfg_lock_count` consecutive reference periods have passed with every pump pulse shorter than LOCK_WIN cycles. A pulse of LOCK_WIN cycles or more clears the count at the next `ref_tick`. With LOCK_WIN = 4 and a 5-cycle phase lag, `locked` is low in the cycle after that tick.
- R10: In the cycle after `locked` falls, the fast-acquire window restarts, so `boost` is high in that cycle when enabled.
- R11: After reset, `pump_src`, `pump_sink`, `boost`, `locked`, `mod_sel`, `ref_tick` and `fb_tick` are low, and `pump_code` equals `cfg_cur_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Divider write strobe; restarts dividers, detector, lock count and boost window |
| cfg_ref_div | input | 14 | Reference division ratio R |
| cfg_a | input | 3 | Swallow count A |
| cfg_b | input | 13 | Main count B |
| cfg_pump_mode | input | 2 | Manual pump mode |
| cfg_invert | input | 1 | Pump polarity swap |
| cfg_cur_code | input | 3 | Normal pump current code |
| cfg_fa_en | input | 1 | Fast-acquire enable |
| cfg_fa_units | input | 14 | Boost window length in reference periods |
| cfg_lock_count | input | 4 | Good periods needed for lock |
| pre_edge | input | 1 | One-cycle strobe per prescaler output pulse |
| mod_sel | output | 1 | Prescaler modulus select, 1 = divide-by-9 |
| ref_tick | output | 1 | Reference divider output |
| fb_tick | output | 1 | Feedback divider output |
| pump_src | output | 1 | Pump source-current command |
| pump_sink | output | 1 | Pump sink-current command |
| pump_code | output | 3 | Pump current code |
| boost | output | 1 | Fast-acquire window active |
| locked | output | 1 | Lock indication |

## Verification
Several properties are checked on every cycle. The pump never sources and sinks at once, and the feedback tick only appears on a prescaler pulse. Reference ticks never fall in consecutive cycles, and the modulus select rises only at a divider reload. Boost needs its enable and starts only on a load, an enable edge or a lock loss. The exact counts can only be shown by bench scenarios: the tick spacing, the 8/9 split per feedback period, the boost window length, the pulse width for a given phase lag, and the cycle in which lock is gained and lost.

// File: rtl/syn_divctl_pkg.sv
package syn_divctl_pkg;
    localparam int REF_W   = 14;
    localparam int A_W     = 3;
    localparam int B_W     = 13;
    localparam int FA_W    = 14;
    localparam int CUR_W   = 3;
    localparam int LOCK_CW = 4;

    typedef enum logic [1:0] {
        PM_NORMAL   = 2'd0,
        PM_FORCE_UP = 2'd1,
        PM_FORCE_DN = 2'd2,
        PM_OFF      = 2'd3
    } pump_mode_e;
endpackage

// File: rtl/syn_ref_div.sv
module syn_ref_div #(
    parameter int W = syn_divctl_pkg::REF_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] ratio,
    output logic         tick
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t s_q, s_d;

    assign tick = (s_q.cnt >= ratio - W'(1));

    always_comb begin
        s_d = s_q;
        if (load || tick) s_d.cnt = '0;
        else              s_d.cnt = s_q.cnt + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/syn_fb_div.sv
module syn_fb_div #(
    parameter int AW = syn_divctl_pkg::A_W,
    parameter int BW = syn_divctl_pkg::B_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] swallow,
    input  logic [BW-1:0] main_cnt,
    input  logic          pre_edge,
    output logic          mod_sel,
    output logic          tick
);
    typedef struct packed {
        logic [AW-1:0] a_left;
        logic [BW-1:0] b_seen;
    } st_t;

    st_t s_q, s_d;

    assign mod_sel = (s_q.a_left != '0);
    assign tick    = pre_edge && (s_q.b_seen >= main_cnt - BW'(1));

    always_comb begin
        s_d = s_q;
        if (load || tick) begin
            s_d.a_left = swallow;
            s_d.b_seen = '0;
        end else if (pre_edge) begin
            s_d.b_seen = s_q.b_seen + BW'(1);
            if (s_q.a_left != '0) s_d.a_left = s_q.a_left - AW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/syn_pfd_lock.sv
module syn_pfd_lock #(
    parameter int LOCK_WIN = 4,
    parameter int CW       = syn_divctl_pkg::LOCK_CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          ref_tick,
    input  logic          fb_tick,
    input  logic [CW-1:0] need,
    output logic          up,
    output logic          dn,
    output logic          locked
);
    localparam int WW = $clog2(LOCK_WIN + 1);
    localparam logic [WW-1:0] WMAX = WW'(LOCK_WIN);

    typedef struct packed {
        logic          up;
        logic          dn;
        logic [WW-1:0] width;
        logic          wide;
        logic [CW-1:0] good;
    } st_t;

    st_t  s_q, s_d;
    logic up_n, dn_n, bad;

    assign up     = s_q.up;
    assign dn     = s_q.dn;
    assign locked = (s_q.good >= need) && (s_q.good != '0);

    always_comb begin
        s_d  = s_q;
        up_n = s_q.up | ref_tick;
        dn_n = s_q.dn | fb_tick;
        if (up_n && dn_n) begin
            up_n = 1'b0;
            dn_n = 1'b0;
        end
        s_d.up = up_n;
        s_d.dn = dn_n;

        if (s_q.up || s_q.dn)
            s_d.width = (s_q.width == WMAX) ? s_q.width : s_q.width + WW'(1);
        else
            s_d.width = '0;

        bad      = s_q.wide || (s_q.width == WMAX);
        s_d.wide = bad;
        if (ref_tick) begin
            s_d.wide = 1'b0;
            if (bad)                  s_d.good = '0;
            else if (s_q.good != '1)  s_d.good = s_q.good + CW'(1);
        end

        if (load) s_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/syn_divctl.sv
module syn_divctl #(
    parameter int REF_W    = syn_divctl_pkg::REF_W,
    parameter int A_W      = syn_divctl_pkg::A_W,
    parameter int B_W      = syn_divctl_pkg::B_W,
    parameter int FA_W     = syn_divctl_pkg::FA_W,
    parameter int CUR_W    = syn_divctl_pkg::CUR_W,
    parameter int LOCK_CW  = syn_divctl_pkg::LOCK_CW,
    parameter int LOCK_WIN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [REF_W-1:0] cfg_ref_div,
    input  logic [A_W-1:0]   cfg_a,
    input  logic [B_W-1:0]   cfg_b,
    input  logic [1:0]       cfg_pump_mode,
    input  logic             cfg_invert,
    input  logic [CUR_W-1:0] cfg_cur_code,
    input  logic             cfg_fa_en,
    input  logic [FA_W-1:0]  cfg_fa_units,
    input  logic [LOCK_CW-1:0] cfg_lock_count,
    input  logic             pre_edge,
    output logic             mod_sel,
    output logic             ref_tick,
    output logic             fb_tick,
    output logic             pump_src,
    output logic             pump_sink,
    output logic [CUR_W-1:0] pump_code,
    output logic             boost,
    output logic             locked
);
    import syn_divctl_pkg::*;

    typedef struct packed {
        logic [FA_W-1:0] fa_left;
        logic            lock_prev;
    } st_t;

    st_t        s_q, s_d;
    logic       det_up, det_dn, req_up, req_dn, restart;
    pump_mode_e mode;

    syn_ref_div #(.W(REF_W)) i_ref_div (
        .clk(clk), .rst_n(rst_n), .load(cfg_load),
        .ratio(cfg_ref_div), .tick(ref_tick)
    );

    syn_fb_div #(.AW(A_W), .BW(B_W)) i_fb_div (
        .clk(clk), .rst_n(rst_n), .load(cfg_load),
        .swallow(cfg_a), .main_cnt(cfg_b), .pre_edge(pre_edge),
        .mod_sel(mod_sel), .tick(fb_tick)
    );

    syn_pfd_lock #(.LOCK_WIN(LOCK_WIN), .CW(LOCK_CW)) i_pfd (
        .clk(clk), .rst_n(rst_n), .load(cfg_load),
        .ref_tick(ref_tick), .fb_tick(fb_tick), .need(cfg_lock_count),
        .up(det_up), .dn(det_dn), .locked(locked)
    );

    assign mode = pump_mode_e'(cfg_pump_mode);

    always_comb begin
        case (mode)
            PM_NORMAL:   begin req_up = det_up; req_dn = det_dn; end
            PM_FORCE_UP: begin req_up = 1'b1;   req_dn = 1'b0;   end
            PM_FORCE_DN: begin req_up = 1'b0;   req_dn = 1'b1;   end
            default:     begin req_up = 1'b0;   req_dn = 1'b0;   end
        endcase
        pump_src  = cfg_invert ? req_dn : req_up;
        pump_sink = cfg_invert ? req_up : req_dn;
    end

    assign boost     = cfg_fa_en && (s_q.fa_left != '0);
    assign pump_code = boost ? '1 : cfg_cur_code;
    assign restart   = cfg_load || (s_q.lock_prev && !locked);

    always_comb begin
        s_d           = s_q;
        s_d.lock_prev = locked;
        if (restart)
            s_d.fa_left = cfg_fa_units;
        else if (ref_tick && (s_q.fa_left != '0))
            s_d.fa_left = s_q.fa_left - FA_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/syn_divctl_chk.sv
module syn_divctl_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_load,
    input logic cfg_fa_en,
    input logic pre_edge,
    input logic ref_tick,
    input logic fb_tick,
    input logic mod_sel,
    input logic pump_src,
    input logic pump_sink,
    input logic boost,
    input logic locked
);
    p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(pump_src && pump_sink));

    p_fb_on_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fb_tick |-> pre_edge);

    p_ref_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tick |=> !ref_tick);

    p_mod_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_sel) |-> $past(cfg_load || fb_tick));

    p_boost_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        boost |-> cfg_fa_en);

    p_boost_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(boost) |-> ($past(cfg_load) || $rose(cfg_fa_en) ||
                          ($past(locked, 2) && !$past(locked))));
endmodule

bind syn_divctl syn_divctl_chk i_chk (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_fa_en(cfg_fa_en),
    .pre_edge(pre_edge), .ref_tick(ref_tick), .fb_tick(fb_tick),
    .mod_sel(mod_sel), .pump_src(pump_src), .pump_sink(pump_sink),
    .boost(boost), .locked(locked)
);

// File: tb/test_syn_divctl.sv
`timescale 1ns/1ps
module test_syn_divctl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_load;
    logic [13:0] cfg_ref_div;
    logic [2:0]  cfg_a;
    logic [12:0] cfg_b;
    logic [1:0]  cfg_pump_mode;
    logic        cfg_invert;
    logic [2:0]  cfg_cur_code;
    logic        cfg_fa_en;
    logic [13:0] cfg_fa_units;
    logic [3:0]  cfg_lock_count;
    logic        pre_edge;
    logic        mod_sel, ref_tick, fb_tick, pump_src, pump_sink, boost, locked;
    logic [2:0]  pump_code;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    syn_divctl i_syn_divctl (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_ref_div(cfg_ref_div),
        .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg_pump_mode(cfg_pump_mode),
        .cfg_invert(cfg_invert), .cfg_cur_code(cfg_cur_code), .cfg_fa_en(cfg_fa_en),
        .cfg_fa_units(cfg_fa_units), .cfg_lock_count(cfg_lock_count),
        .pre_edge(pre_edge), .mod_sel(mod_sel), .ref_tick(ref_tick),
        .fb_tick(fb_tick), .pump_src(pump_src), .pump_sink(pump_sink),
        .pump_code(pump_code), .boost(boost), .locked(locked)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // returns {src, sink}
    function automatic logic [1:0] exp_pump(input logic [1:0] m, input logic inv,
                                            input logic up, input logic dn);
        logic ru, rd;
        case (m)
            2'd0:    begin ru = up;   rd = dn;   end
            2'd1:    begin ru = 1'b1; rd = 1'b0; end
            2'd2:    begin ru = 1'b0; rd = 1'b1; end
            default: begin ru = 1'b0; rd = 1'b0; end
        endcase
        return inv ? {rd, ru} : {ru, rd};
    endfunction

    task automatic do_load();
        @(posedge clk); #1 cfg_load = 1'b1;
        @(posedge clk); #1 cfg_load = 1'b0;
    endtask

    task automatic next_cycle();
        @(posedge clk); #1;
    endtask

    // R1: tick spacing
    task automatic ref_check(input int r, input int span);
        int bad_k = -1;
        cfg_ref_div = 14'(r);
        pre_edge = 1'b0;
        do_load();
        for (int k = 0; k < span; k++) begin
            @(negedge clk);
            if ((ref_tick !== ((k % r) == r - 1)) && bad_k < 0) bad_k = k;
            next_cycle();
        end
        check(bad_k < 0, $sformatf("R1 ratio %0d first bad cycle", r), bad_k, -1);
    endtask

    // R2, R3: pulses per feedback period and divide-by-9 share
    task automatic fb_check(input int a, input int b, input int periods, input bit rnd);
        int pc = 0, mc = 0, seen = 0, guard = 0;
        cfg_a = 3'(a);
        cfg_b = 13'(b);
        do_load();
        while (seen < periods && guard < 40 * b * periods + 100) begin
            pre_edge = rnd ? 1'($urandom_range(0, 1)) : 1'b1;
            @(negedge clk);
            if (pre_edge) begin
                pc++;
                if (mod_sel) mc++;
            end
            if (fb_tick) begin
                check(pc == b, $sformatf("R2 pulses per period A=%0d B=%0d", a, b), pc, b);
                check(mc == a, $sformatf("R3 modulus-9 pulses A=%0d B=%0d", a, b), mc, a);
                pc = 0; mc = 0; seen++;
            end
            next_cycle();
            guard++;
        end
        check(seen == periods, "R2 feedback periods seen", seen, periods);
        pre_edge = 1'b0;
    endtask

    // R8: boost window length
    task automatic fa_window(input int u, input int r);
        int cnt = 0;
        cfg_fa_en = 1'b1;
        cfg_fa_units = 14'(u);
        cfg_ref_div = 14'(r);
        pre_edge = 1'b0;
        do_load();
        for (int k = 0; k < u * r + 2 * r; k++) begin
            @(negedge clk);
            if (boost) begin
                cnt++;
                if (pump_code !== 3'd7) check(1'b0, "R7 boosted code", pump_code, 7);
            end
            next_cycle();
        end
        check(cnt == u * r, $sformatf("R8 window U=%0d R=%0d", u, r), cnt, u * r);
    endtask

    initial begin
        #(8 * 200000);
        check(1'b0, "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0; cfg_load = 1'b0; cfg_ref_div = 14'd56; cfg_a = 3'd5; cfg_b = 13'h1D;
        cfg_pump_mode = 2'd0; cfg_invert = 1'b0; cfg_cur_code = 3'd2; cfg_fa_en = 1'b0;
        cfg_fa_units = 14'd4; cfg_lock_count = 4'd3; pre_edge = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({pump_src, pump_sink, boost, locked, mod_sel, ref_tick, fb_tick} == 7'b0,
              "R11 outputs idle in reset",
              {pump_src, pump_sink, boost, locked, mod_sel, ref_tick, fb_tick}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pump_code == cfg_cur_code, "R11 code after reset", pump_code, cfg_cur_code);
        check({pump_src, pump_sink, boost, locked} == 4'b0, "R11 idle after reset",
              {pump_src, pump_sink, boost, locked}, 0);

        // R1: boundary and random ratios
        ref_check(3, 12);
        ref_check(56, 170);
        for (int i = 0; i < 3; i++) ref_check($urandom_range(4, 40), 120);
        ref_check(16383, 2 * 16383);

        // R2/R3: defaults, boundaries and random
        fb_check(5, 29, 3, 1'b1);
        fb_check(7, 7, 3, 1'b0);
        fb_check(0, 1, 3, 1'b1);
        for (int i = 0; i < 4; i++) begin
            int b = $urandom_range(1, 20);
            int a = $urandom_range(0, (b < 7) ? b : 7);
            fb_check(a, b, 3, 1'b1);
        end

        // R4/R9/R10: coincident ticks, lock gain, phase lag, lock loss
        begin
            int run = 0, first_w = -1, fall_k = -1, overlap = 0;
            bit prev_locked = 1'b0;
            cfg_ref_div = 14'd10; cfg_a = 3'd0; cfg_b = 13'd10; cfg_lock_count = 4'd3;
            cfg_pump_mode = 2'd0; cfg_invert = 1'b0; cfg_fa_en = 1'b1; cfg_fa_units = 14'd2;
            pre_edge = 1'b1;
            do_load();
            for (int k = 0; k < 120; k++) begin
                pre_edge = !(k >= 50 && k < 55);
                @(negedge clk);
                if (k < 50 && (pump_src || pump_sink)) overlap++;
                if (k == 25) check(locked == 1'b0, "R9 not yet locked", locked, 0);
                if (k == 35) check(locked == 1'b1, "R9 locked after 3 periods", locked, 1);
                if (k == 19) check(boost == 1'b1, "R8 boost last cycle", boost, 1);
                if (k == 20) check(boost == 1'b0, "R8 boost ended", boost, 0);
                if (k == 5)  check(pump_code == 3'd7, "R7 code in boost", pump_code, 7);
                if (k == 40) check(pump_code == cfg_cur_code, "R7 code normal", pump_code, cfg_cur_code);
                if (pump_src) run++;
                else begin
                    if (run > 0 && first_w < 0) first_w = run;
                    run = 0;
                end
                if (prev_locked && !locked && fall_k < 0) fall_k = k;
                if (fall_k >= 0 && k == fall_k + 1)
                    check(boost == 1'b1 && pump_code == 3'd7, "R10 boost after lock loss", boost, 1);
                prev_locked = locked;
                next_cycle();
            end
            check(overlap == 0, "R4 coincident ticks give no pulse", overlap, 0);
            check(first_w == 5, "R4 up pulse width equals lag", first_w, 5);
            check(fall_k == 70, "R9 lock lost cycle", fall_k, 70);
        end

        // R5/R6: overrides and polarity, idle detector then pending up
        begin
            cfg_ref_div = 14'd20; cfg_fa_en = 1'b0; pre_edge = 1'b0;
            do_load();
            for (int k = 0; k < 33; k++) begin
                logic [1:0] exp;
                logic [1:0] m = 2'(k % 4);
                logic inv = ((k / 4) % 2) == 1;
                cfg_pump_mode = m; cfg_invert = inv;
                @(negedge clk);
                if (k < 8 || (k >= 25 && k < 33)) begin
                    exp = exp_pump(m, inv, k >= 25, 1'b0);
                    check({pump_src, pump_sink} == exp,
                          $sformatf("R5 R6 mode %0d invert %0d", m, inv),
                          {pump_src, pump_sink}, exp);
                end
                next_cycle();
            end
            cfg_pump_mode = 2'd0; cfg_invert = 1'b0;
        end

        // R8 disabled, R7 random codes
        begin
            int bad = 0;
            cfg_fa_en = 1'b0; cfg_fa_units = 14'd3; cfg_ref_div = 14'd5;
            do_load();
            for (int k = 0; k < 30; k++) begin
                cfg_cur_code = 3'($urandom_range(0, 7));
                @(negedge clk);
                if (boost || pump_code != cfg_cur_code) bad++;
                next_cycle();
            end
            check(bad == 0, "R8 R7 no boost when disabled", bad, 0);
        end

        fa_window(1, 3);
        fa_window(4, 56 / 16 + 3);
        for (int i = 0; i < 2; i++) fa_window($urandom_range(1, 5), $urandom_range(3, 20));

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule